// File: doc/BRIEF.md
# Data-Processing ALU with Carry Chaining

This block is the integer data-processing unit of a RISC execution stage. It takes a 4-bit operation code, two 32-bit operands and the current carry and overflow flags. It returns a 32-bit result, a write enable for the destination register, and the next N, Z, C and V flags. The unit is purely combinational. The surrounding pipeline registers its outputs and decides whether to commit them.

The sixteen operations fall into four flag classes:

- **Logical:** AND, XOR, OR, bit-clear, move, move-not, and the two test forms.
- **Add:** add, add-with-carry, compare-negative.
- **Subtract:** subtract, subtract-with-carry, compare.
- **Reverse subtract:** the plain and carry forms, which swap the operands before subtracting.

Carry-chained subtraction uses an inverted borrow: a set carry means "no borrow pending". The four compare and test operations produce flags only.

An immediate mode replaces the second operand with an 8-bit constant rotated right by twice a 4-bit rotate field. The operation map stays the same in this mode.

Top module: `dp_alu`

## Requirements
- R1: Logical operations compute the result as follows: code 0 `a&b`, 1 `a^b`, 8 `a&b`, 9 `a^b`, C `a|b`, D `b`, E `a&~b`, F `~b`. For all of them C equals `c_in` and V equals `v_in`.
- R2: Add-class codes 4 (`a+b`), 5 (`a+b+c_in`) and B (`a+b`) give the low 32 bits of the sum. C is the unsigned carry out and V is two's-complement overflow.
- R3: Subtract-class codes 2 (`a-b`), 6 (`a-b-!c_in`) and A (`a-b`) give the difference. C is 1 exactly when no borrow occurs and V is signed overflow.
- R4: Reverse codes 3 (`b-a`) and 7 (`b-a-!c_in`) use the operands swapped, with the flags of R3 computed on the swapped operands.
- R5: The carry input changes only codes 5, 6 and 7. With `c_in`=0, code 6 on equal operands gives 0xFFFFFFFF with C=0. With `c_in`=1 it gives 0 with C=1.
- R6: `wr_en` is 0 for codes 8 to B (`opc[3:2]`=2'b10) and 1 for every other code. The computed value still appears on `result`.
- R7: For every code, N equals `result[31]` and Z is 1 exactly when `result` is zero.
- R8: When `use_imm`=1 the second operand is `imm_val` zero-extended and rotated right by `2*imm_rot` bits, and `op_b` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register form) |
| use_imm | input | 1 | Select rotated immediate as second operand |
| imm_val | input | 8 | Immediate constant |
| imm_rot | input | 4 | Rotate field, rotation is twice this value |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |

## Verification
The bench targets several carry and overflow boundaries. These are 0x7FFFFFFF+1, where a design that takes V from the unsigned carry shows no overflow, and 0-1, where a design that reports borrow instead of NOT-borrow inverts C. It also covers subtract-with-carry on equal operands with both carry values, which exposes a polarity swap of the borrow. Reverse subtraction is checked with asymmetric operands, so forgetting to swap the flag operands shows up as wrong C and V. The remaining targets are write-enable masking on the four compare codes, rotations by 0 and 30 bits where a wrap error moves the constant, and the assurance that `op_b` is ignored in immediate mode.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ADD   = 2'd1,
    CLS_SUB   = 2'd2,
    CLS_REV   = 2'd3
  } flag_cls_e;

  typedef enum logic [2:0] {
    LG_AND = 3'd0,
    LG_XOR = 3'd1,
    LG_OR  = 3'd2,
    LG_MOV = 3'd3,
    LG_BIC = 3'd4,
    LG_MVN = 3'd5
  } logic_fn_e;

  typedef struct packed {
    flag_cls_e cls;
    logic_fn_e lfn;
    logic      use_carry;
    logic      wr_en;
  } op_ctrl_t;
endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] opc,
  output op_ctrl_t   ctrl
);
  always_comb begin
    ctrl           = '0;
    ctrl.cls       = CLS_LOGIC;
    ctrl.lfn       = LG_AND;
    ctrl.use_carry = 1'b0;
    ctrl.wr_en     = (opc[3:2] != 2'b10);
    unique case (opc)
      4'h0, 4'h8: ctrl.lfn = LG_AND;
      4'h1, 4'h9: ctrl.lfn = LG_XOR;
      4'h2, 4'hA: ctrl.cls = CLS_SUB;
      4'h3:       ctrl.cls = CLS_REV;
      4'h4, 4'hB: ctrl.cls = CLS_ADD;
      4'h5: begin
        ctrl.cls       = CLS_ADD;
        ctrl.use_carry = 1'b1;
      end
      4'h6: begin
        ctrl.cls       = CLS_SUB;
        ctrl.use_carry = 1'b1;
      end
      4'h7: begin
        ctrl.cls       = CLS_REV;
        ctrl.use_carry = 1'b1;
      end
      4'hC: ctrl.lfn = LG_OR;
      4'hD: ctrl.lfn = LG_MOV;
      4'hE: ctrl.lfn = LG_BIC;
      4'hF: ctrl.lfn = LG_MVN;
      default: ctrl.lfn = LG_AND;
    endcase
  end
endmodule

// File: rtl/dp_alu_imm_rot.sv
module dp_alu_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_val,
  input  logic [ROT_W-1:0]  imm_rot,
  output logic [DATA_W-1:0] imm_word
);
  localparam int SH_W = ROT_W + 1;

  logic [DATA_W-1:0]   base;
  logic [2*DATA_W-1:0] twice;
  logic [2*DATA_W-1:0] shifted;
  logic [SH_W-1:0]     amount;

  assign base    = {{(DATA_W-IMM_W){1'b0}}, imm_val};
  assign amount  = {imm_rot, 1'b0};
  assign twice   = {base, base};
  assign shifted = twice >> amount;
  assign imm_word = shifted[DATA_W-1:0];
endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  flag_cls_e         cls,
  input  logic              use_carry,
  input  logic              c_in,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] x_opnd;
  logic [DATA_W-1:0] y_opnd;
  logic              cin_bit;
  logic [DATA_W:0]   wide;

  always_comb begin
    x_opnd  = a;
    y_opnd  = b;
    cin_bit = use_carry ? c_in : 1'b0;
    unique case (cls)
      CLS_SUB: begin
        y_opnd  = ~b;
        cin_bit = use_carry ? c_in : 1'b1;
      end
      CLS_REV: begin
        x_opnd  = b;
        y_opnd  = ~a;
        cin_bit = use_carry ? c_in : 1'b1;
      end
      default: ;
    endcase
  end

  assign wide  = {1'b0, x_opnd} + {1'b0, y_opnd} + {{DATA_W{1'b0}}, cin_bit};
  assign sum   = wide[DATA_W-1:0];
  assign carry = wide[DATA_W];
  assign ovf   = (x_opnd[MSB] == y_opnd[MSB]) && (wide[MSB] != x_opnd[MSB]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic_fn_e         lfn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (lfn)
      LG_AND:  res = a & b;
      LG_XOR:  res = a ^ b;
      LG_OR:   res = a | b;
      LG_MOV:  res = b;
      LG_BIC:  res = a & ~b;
      LG_MVN:  res = ~b;
      default: res = a & b;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [3:0]        opc,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic [ROT_W-1:0]  imm_rot,
  input  logic              c_in,
  input  logic              v_in,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              n_out,
  output logic              z_out,
  output logic              c_out,
  output logic              v_out
);
  op_ctrl_t          ctrl;
  logic [DATA_W-1:0] imm_word;
  logic [DATA_W-1:0] opnd2;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic              arith_c;
  logic              arith_v;

  dp_alu_decode u_decode (
    .opc  (opc),
    .ctrl (ctrl)
  );

  dp_alu_imm_rot #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
  ) u_imm (
    .imm_val  (imm_val),
    .imm_rot  (imm_rot),
    .imm_word (imm_word)
  );

  assign opnd2 = use_imm ? imm_word : op_b;

  dp_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .cls       (ctrl.cls),
    .use_carry (ctrl.use_carry),
    .c_in      (c_in),
    .a         (op_a),
    .b         (opnd2),
    .sum       (arith_res),
    .carry     (arith_c),
    .ovf       (arith_v)
  );

  dp_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .lfn (ctrl.lfn),
    .a   (op_a),
    .b   (opnd2),
    .res (logic_res)
  );

  always_comb begin
    if (ctrl.cls == CLS_LOGIC) begin
      result = logic_res;
      c_out  = c_in;
      v_out  = v_in;
    end else begin
      result = arith_res;
      c_out  = arith_c;
      v_out  = arith_v;
    end
    n_out = result[DATA_W-1];
    z_out = (result == '0);
    wr_en = ctrl.wr_en;
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input logic [3:0]        opc,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              use_imm,
  input logic [IMM_W-1:0]  imm_val,
  input logic [ROT_W-1:0]  imm_rot,
  input logic              c_in,
  input logic              v_in,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic              n_out,
  input logic              z_out,
  input logic              c_out,
  input logic              v_out
);
  logic is_logic;
  assign is_logic = (opc inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF});

  always_comb begin
    if (opc[3:2] == 2'b10) begin
      assert_no_write_cmp_R6: assert (!wr_en) else $error("R6 write on compare");
    end else begin
      assert_write_other_R6: assert (wr_en) else $error("R6 missing write");
    end
    assert_zero_flag_R7: assert (z_out == (result == '0)) else $error("R7 Z mismatch");
    assert_neg_flag_R7: assert (n_out == result[DATA_W-1]) else $error("R7 N mismatch");
    if (is_logic) begin
      assert_flags_pass_R1: assert (c_out == c_in && v_out == v_in) else $error("R1 flag pass");
    end
    if (opc == 4'hD && !use_imm) begin
      assert_move_reg_R1: assert (result == op_b) else $error("R1 move");
    end
    if (opc == 4'hD && use_imm && imm_rot == '0) begin
      assert_imm_plain_R8: assert (result == {{(DATA_W-IMM_W){1'b0}}, imm_val}) else $error("R8 imm");
    end
    if (opc == 4'h2 && op_a == op_b && !use_imm) begin
      assert_sub_equal_R3: assert (result == '0 && c_out && !v_out) else $error("R3 equal sub");
    end
  end
endmodule

bind dp_alu dp_alu_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .ROT_W  (ROT_W)
) u_chk (
  .opc     (opc),
  .op_a    (op_a),
  .op_b    (op_b),
  .use_imm (use_imm),
  .imm_val (imm_val),
  .imm_rot (imm_rot),
  .c_in    (c_in),
  .v_in    (v_in),
  .result  (result),
  .wr_en   (wr_en),
  .n_out   (n_out),
  .z_out   (z_out),
  .c_out   (c_out),
  .v_out   (v_out)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
  logic        clk;
  logic        rst_n;
  logic [3:0]  opc;
  logic [31:0] op_a, op_b;
  logic        use_imm;
  logic [7:0]  imm_val;
  logic [3:0]  imm_rot;
  logic        c_in, v_in;
  logic [31:0] result;
  logic        wr_en, n_out, z_out, c_out, v_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dp_alu u_dut (
    .opc (opc), .op_a (op_a), .op_b (op_b), .use_imm (use_imm),
    .imm_val (imm_val), .imm_rot (imm_rot), .c_in (c_in), .v_in (v_in),
    .result (result), .wr_en (wr_en), .n_out (n_out), .z_out (z_out),
    .c_out (c_out), .v_out (v_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] res;
    logic        we, n, z, c, v;
  } exp_t;

  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic c, input logic v);
    exp_t e;
    longint unsigned ua, ub, ut;
    longint sa, sb, st;
    logic [31:0] x, y;
    int brw;
    e.c = c; e.v = v; e.res = 0;
    e.we = !(op >= 4'h8 && op <= 4'hB);
    case (op)
      4'h0, 4'h8: e.res = a & b;
      4'h1, 4'h9: e.res = a ^ b;
      4'hC: e.res = a | b;
      4'hD: e.res = b;
      4'hE: e.res = a & ~b;
      4'hF: e.res = ~b;
      4'h4, 4'h5, 4'hB: begin
        ua = {32'd0, a}; ub = {32'd0, b};
        sa = longint'($signed(a)); sb = longint'($signed(b));
        brw = (op == 4'h5) ? int'(c) : 0;
        ut = ua + ub + longint'(brw);
        st = sa + sb + longint'(brw);
        e.res = ut[31:0];
        e.c = ut[32];
        e.v = (st > 64'sd2147483647) || (st < -64'sd2147483648);
      end
      default: begin
        if (op == 4'h3 || op == 4'h7) begin x = b; y = a; end
        else begin x = a; y = b; end
        brw = ((op == 4'h6 || op == 4'h7) && !c) ? 1 : 0;
        ua = {32'd0, x}; ub = {32'd0, y};
        sa = longint'($signed(x)); sb = longint'($signed(y));
        st = sa - sb - longint'(brw);
        e.res = x - y - 32'(brw);
        e.c = (ua >= ub + longint'(brw));
        e.v = (st > 64'sd2147483647) || (st < -64'sd2147483648);
      end
    endcase
    e.n = e.res[31];
    e.z = (e.res == 0);
    return e;
  endfunction

  function automatic logic [31:0] rot_ref(input logic [7:0] iv, input logic [3:0] r);
    logic [31:0] w;
    w = {24'd0, iv};
    for (int k = 0; k < 2 * int'(r); k++) w = {w[0], w[31:1]};
    return w;
  endfunction

  task automatic compare(input string req, input exp_t e);
    checks++;
    if (result !== e.res || wr_en !== e.we || n_out !== e.n || z_out !== e.z ||
        c_out !== e.c || v_out !== e.v) begin
      errors++;
      $display("FAIL %s opc=%h a=%h b=%h: got res=%h we=%b nzcv=%b%b%b%b exp res=%h we=%b nzcv=%b%b%b%b",
               req, opc, op_a, op_b, result, wr_en, n_out, z_out, c_out, v_out,
               e.res, e.we, e.n, e.z, e.c, e.v);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic c, input logic v, input string req);
    @(negedge clk);
    opc = op; op_a = a; op_b = b; c_in = c; v_in = v; use_imm = 1'b0;
    #1;
    compare(req, model(op, a, b, c, v));
  endtask

  task automatic t_idle;
    apply(4'h0, 32'd0, 32'd0, 1'b0, 1'b0, "R7 idle zero");
  endtask

  task automatic t_logic;
    for (int i = 0; i < 40; i++) begin
      logic [3:0] ops [8] = '{4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF};
      apply(ops[i % 8], $urandom, $urandom, 1'(i / 8), 1'(i / 4), "R1 logical");
    end
  endtask

  task automatic t_add;
    apply(4'h4, 32'h7FFFFFFF, 32'd1, 1'b0, 1'b0, "R2 signed overflow");
    apply(4'h4, 32'hFFFFFFFF, 32'd1, 1'b0, 1'b0, "R2 carry out zero");
    apply(4'hB, 32'h80000000, 32'h80000000, 1'b0, 1'b0, "R2 cmn overflow");
    apply(4'h5, 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0, "R5 adc carry in");
    for (int i = 0; i < 60; i++) begin
      logic [3:0] ops [3] = '{4'h4, 4'h5, 4'hB};
      apply(ops[i % 3], $urandom, $urandom, 1'(i & 1), 1'b0, "R2 add class");
    end
  endtask

  task automatic t_sub;
    apply(4'h2, 32'd0, 32'd1, 1'b1, 1'b0, "R3 borrow");
    apply(4'h2, 32'h80000000, 32'd1, 1'b0, 1'b0, "R3 signed overflow");
    apply(4'hA, 32'd5, 32'd5, 1'b0, 1'b1, "R3 compare equal");
    for (int i = 0; i < 60; i++) begin
      logic [3:0] ops [3] = '{4'h2, 4'h6, 4'hA};
      apply(ops[i % 3], $urandom, $urandom, 1'(i & 1), 1'b0, "R3 sub class");
    end
  endtask

  task automatic t_rev;
    apply(4'h3, 32'd1, 32'd10, 1'b0, 1'b0, "R4 rsb no borrow");
    apply(4'h3, 32'd10, 32'd1, 1'b0, 1'b0, "R4 rsb borrow");
    apply(4'h7, 32'd3, 32'd3, 1'b0, 1'b0, "R4 rsc borrow in");
    for (int i = 0; i < 40; i++)
      apply(4'h3 + 4'(4 * (i & 1)), $urandom, $urandom, 1'(i >> 1), 1'b1, "R4 reverse");
  endtask

  task automatic t_carry_chain;
    apply(4'h6, 32'h1234, 32'h1234, 1'b0, 1'b0, "R5 sbc c=0");
    checks++;
    if (result !== 32'hFFFFFFFF || c_out !== 1'b0) begin
      errors++;
      $display("FAIL R5 sbc c=0 res=%h c=%b exp ffffffff 0", result, c_out);
    end
    apply(4'h6, 32'h1234, 32'h1234, 1'b1, 1'b0, "R5 sbc c=1");
    checks++;
    if (result !== 32'd0 || c_out !== 1'b1) begin
      errors++;
      $display("FAIL R5 sbc c=1 res=%h c=%b exp 0 1", result, c_out);
    end
    apply(4'h4, 32'd7, 32'd8, 1'b1, 1'b0, "R5 add ignores carry");
  endtask

  task automatic t_write_mask;
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 2; c++)
        apply(4'(op), $urandom, $urandom, 1'(c), 1'(c), "R6 write enable");
  endtask

  task automatic t_imm;
    for (int r = 0; r < 16; r++) begin
      logic [7:0] iv;
      logic [31:0] w;
      exp_t e;
      iv = 8'(r * 17 + 3);
      w  = rot_ref(iv, 4'(r));
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        opc = (r & 1) ? 4'h4 : 4'hD;
        op_a = 32'h0F0F0001; op_b = k ? 32'hDEADBEEF : 32'h0;
        use_imm = 1'b1; imm_val = iv; imm_rot = 4'(r); c_in = 1'b1; v_in = 1'b0;
        #1;
        e = model(opc, op_a, w, c_in, v_in);
        compare("R8 immediate", e);
      end
    end
    use_imm = 1'b0;
  endtask

  initial begin
    opc = 0; op_a = 0; op_b = 0; use_imm = 0; imm_val = 0; imm_rot = 0;
    c_in = 0; v_in = 0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_rev();
    t_carry_chain();
    t_write_mask();
    t_imm();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule